// File: doc/BRIEF.md
# Aligned Load/Store Byte Lane Unit

This block sits between the memory stage of a load/store pipeline and a 64-bit, byte-addressed data memory. For each request it takes an address, an access size (byte, half word, word or double word), a store flag, store data, an unsigned-load flag and a runtime endianness select. It works out which of the eight byte lanes of the memory word the access touches. For stores it produces the lane enables, a write strobe and write data that has been moved into those lanes. For loads it takes the addressed field out of the returned 64-bit word and sign-extends or zero-extends it to 64 bits.

An access is legal only when its address is a whole multiple of its size. The unit flags any other access as misaligned and does not try to split it into several aligned references. When it flags an access it enables no lane, writes nothing and returns a zero load value. All lane logic is combinational. A parameter chooses whether the results go through one output register stage (the default) or leave the block in the same cycle.

Top module: `lsu_lane_unit`

## Requirements
- R1: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. For an aligned valid access, `byte_en` has exactly that many bits set, and they are contiguous. Bit i of `byte_en` stands for lane i, which is data bits 8i+7..8i.
- R2: When `big_endian`=0, the byte at address offset o (o = `req_addr[2:0]`) sits in lane o. Value byte k (k=0 is the least significant) sits in lane o+k.
- R3: When `big_endian`=1, the byte at address offset o sits in lane 7-o. Value byte k of an S-byte access sits in lane 8-o-S+k.
- R4: An access is misaligned when o mod S is not 0. In that case `misalign`=1, `byte_en`=0, `mem_we`=0, `mem_wdata`=0 and `load_data`=0.
- R5: An aligned valid store sets `mem_we`=1 and places the low S bytes of `store_data` in the enabled lanes. Every lane that is not enabled carries zero in `mem_wdata`.
- R6: An aligned valid load with `req_unsigned`=0 returns the field read from `mem_rdata`, sign-extended to 64 bits from its top bit.
- R7: An aligned valid load with `req_unsigned`=1 returns the field zero-extended to 64 bits.
- R8: When `req_valid`=0, every output is zero. Address bits above bit 2 have no effect on any output.
- R9: With `OUT_REG`=1, outputs follow the request with one clock of latency. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (see R1) |
| req_addr | input | ADDR_W | Byte address |
| req_unsigned | input | 1 | Zero-extend load result |
| big_endian | input | 1 | Lane order select |
| store_data | input | 64 | Store value, right-justified |
| mem_rdata | input | 64 | Word returned by memory for this request |
| out_valid | output | 1 | Result valid |
| byte_en | output | 8 | Lane enables |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 64 | Lane-placed write data |
| misalign | output | 1 | Access not aligned to its size |
| load_data | output | 64 | Extended load value |

## Verification
Misalignment detection and the store write path act in the same cycle: an unaligned store must raise the flag and, in that same result, suppress both the lane enables and the write strobe. The bench provokes this by sweeping every offset for every size in both endian modes, with the store flag both set and clear. It judges each result against a lane model computed in the bench: for a flagged store, `mem_we`=0 and `byte_en`=0; for an aligned store, exactly the modelled lanes are enabled.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int LANES  = 8;
    localparam int DATA_W = LANES * 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic              misalign;
        logic [LANES-1:0]  byte_en;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] ldata;
    } lane_result_t;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
(
    input  logic [OFF_W-1:0] offset_i,
    input  acc_size_e        size_i,
    input  logic             big_endian_i,
    output logic             misalign_o,
    output logic [OFF_W-1:0] lane_shift_o,
    output logic [LANES-1:0] lane_mask_o
);
    logic [OFF_W:0]   nbytes;
    logic [OFF_W:0]   be_shift;
    logic [LANES-1:0] field_mask;

    always_comb begin
        nbytes     = (OFF_W+1)'(1) << size_i;
        misalign_o = |(offset_i & OFF_W'(nbytes - (OFF_W+1)'(1)));
        be_shift   = (OFF_W+1)'(LANES) - {1'b0, offset_i} - nbytes;
        lane_shift_o = big_endian_i ? be_shift[OFF_W-1:0] : offset_i;
        case (size_i)
            SZ_BYTE:  field_mask = LANES'(8'h01);
            SZ_HALF:  field_mask = LANES'(8'h03);
            SZ_WORD:  field_mask = LANES'(8'h0F);
            default:  field_mask = LANES'(8'hFF);
        endcase
        lane_mask_o = misalign_o ? '0 : (field_mask << lane_shift_o);
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_lane_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic [OFF_W-1:0]  lane_shift_i,
    input  logic [DATA_W-1:0] store_data_i,
    output logic [DATA_W-1:0] wdata_o
);
    logic [DATA_W-1:0] keep_bits;
    logic [DATA_W-1:0] field;

    for (genvar b = 0; b < LANES; b++) begin : g_keep
        assign keep_bits[b*8 +: 8] = {8{b < (1 << size_i)}};
    end

    always_comb begin
        field   = store_data_i & keep_bits;
        wdata_o = field << {lane_shift_i, 3'b000};
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic [OFF_W-1:0]  lane_shift_i,
    input  logic              unsigned_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] ldata_o
);
    logic [DATA_W-1:0] aligned;
    logic              fill;

    always_comb begin
        aligned = rdata_i >> {lane_shift_i, 3'b000};
        case (size_i)
            SZ_BYTE: begin
                fill    = ~unsigned_i & aligned[7];
                ldata_o = {{(DATA_W-8){fill}}, aligned[7:0]};
            end
            SZ_HALF: begin
                fill    = ~unsigned_i & aligned[15];
                ldata_o = {{(DATA_W-16){fill}}, aligned[15:0]};
            end
            SZ_WORD: begin
                fill    = ~unsigned_i & aligned[31];
                ldata_o = {{(DATA_W-32){fill}}, aligned[31:0]};
            end
            default: begin
                fill    = 1'b0;
                ldata_o = aligned;
            end
        endcase
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_unsigned,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] store_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [LANES-1:0]  byte_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misalign,
    output logic [DATA_W-1:0] load_data
);
    acc_size_e         size_c;
    logic              mis_c;
    logic [OFF_W-1:0]  shift_c;
    logic [LANES-1:0]  mask_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] ldata_c;
    lane_result_t      res_d;
    lane_result_t      res_q;

    assign size_c = acc_size_e'(req_size);

    lsu_align_check u_align (
        .offset_i     (req_addr[OFF_W-1:0]),
        .size_i       (size_c),
        .big_endian_i (big_endian),
        .misalign_o   (mis_c),
        .lane_shift_o (shift_c),
        .lane_mask_o  (mask_c)
    );

    lsu_store_lanes u_store (
        .size_i       (size_c),
        .lane_shift_i (shift_c),
        .store_data_i (store_data),
        .wdata_o      (wdata_c)
    );

    lsu_load_extract u_load (
        .size_i       (size_c),
        .lane_shift_i (shift_c),
        .unsigned_i   (req_unsigned),
        .rdata_i      (mem_rdata),
        .ldata_o      (ldata_c)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid    = 1'b1;
            res_d.misalign = mis_c;
            if (!mis_c) begin
                res_d.byte_en = mask_c;
                if (req_store) begin
                    res_d.we    = 1'b1;
                    res_d.wdata = wdata_c;
                end else begin
                    res_d.ldata = ldata_c;
                end
            end
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign out_valid = res_q.valid;
    assign byte_en   = res_q.byte_en;
    assign mem_we    = res_q.we;
    assign mem_wdata = res_q.wdata;
    assign misalign  = res_q.misalign;
    assign load_data = res_q.ldata;

    // Lane computation never spills past the top lane for a legal request
    assert_lane_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mis_c) |-> (({1'b0, shift_c} + (4'd1 << req_size)) <= 4'd8));

    assert_misalign_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (byte_en == '0 && !mem_we && load_data == '0));

    assert_store_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (out_valid && $countones(byte_en) >= 1 && !misalign));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (byte_en == '0 && !mem_we && !misalign));

    if (OUT_REG) begin : g_lat_chk
        assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(req_valid)));
    end
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0;
    logic        req_unsigned = 1'b0;
    logic        big_endian = 1'b0;
    logic [63:0] store_data = '0;
    logic [63:0] mem_rdata = '0;
    logic        out_valid;
    logic [7:0]  byte_en;
    logic        mem_we;
    logic [63:0] mem_wdata;
    logic        misalign;
    logic [63:0] load_data;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_unsigned(req_unsigned),
        .big_endian(big_endian), .store_data(store_data), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .byte_en(byte_en), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .misalign(misalign), .load_data(load_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    logic [7:0]  e_en;
    logic [63:0] e_wd, e_ld;
    logic        e_mis;

    task automatic model(input int sz, input int off, input bit be, input bit st,
                         input bit uns, input logic [63:0] sd, input logic [63:0] rd);
        int s = 1 << sz;
        int sh = be ? (8 - off - s) : off;
        e_mis = (off % s) != 0;
        e_en = '0; e_wd = '0; e_ld = '0;
        if (!e_mis) begin
            for (int k = 0; k < s; k++) begin
                e_en[sh+k] = 1'b1;
                if (st) e_wd[(sh+k)*8 +: 8] = sd[k*8 +: 8];
                else    e_ld[k*8 +: 8] = rd[(sh+k)*8 +: 8];
            end
            if (!st && !uns && e_ld[s*8-1])
                for (int b = s*8; b < 64; b++) e_ld[b] = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state: drive a request under reset, outputs must stay zero (R9)
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b1; req_size = 2'd3;
        store_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk); @(negedge clk);
        check(!out_valid && byte_en == 0 && !mem_we && mem_wdata == 0, "R9 reset",
              {out_valid, mem_we, byte_en}, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // Idle with busy inputs (R8)
        check(!out_valid && byte_en == 0 && !mem_we && !misalign && load_data == 0 &&
              mem_wdata == 0, "R8 idle", {out_valid, misalign, byte_en}, 64'd0);

        for (int it = 0; it < 3; it++)
        for (int be = 0; be < 2; be++)
        for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
        for (int un = 0; un < 2; un++) begin
            logic [63:0] sd, rd;
            sd = {$urandom, $urandom};
            rd = {$urandom, $urandom};
            if (it == 0) rd = 64'h80FF_7F01_8000_FF80;
            req_valid = 1'b1; req_store = st[0]; req_size = sz[1:0];
            req_addr = {$urandom} & 32'hFFFF_FFF8 | 32'(off);
            req_unsigned = un[0]; big_endian = be[0];
            store_data = sd; mem_rdata = rd;
            model(sz, off, be[0], st[0], un[0], sd, rd);
            @(negedge clk);
            // R2/R3 placement, R1 lane count, R4 misalign, R5-R7 data paths
            check(out_valid, "R9 latency", {63'd0, out_valid}, 64'd1);
            check(misalign == e_mis, "R4 misalign", {63'd0, misalign}, {63'd0, e_mis});
            check(byte_en == e_en, be ? "R3 big-endian lanes" : "R2 little-endian lanes",
                  {56'd0, byte_en}, {56'd0, e_en});
            check(mem_we == (st != 0 && !e_mis), "R5 write strobe",
                  {63'd0, mem_we}, {63'd0, (st != 0 && !e_mis)});
            check(mem_wdata == e_wd, "R5 write data", mem_wdata, e_wd);
            check(load_data == e_ld, un ? "R7 zero extend" : "R6 sign extend",
                  load_data, e_ld);
        end

        // Back to idle after traffic, upper address bits still toggling (R8)
        req_valid = 1'b0; req_addr = 32'hFFFF_FFF0;
        @(negedge clk);
        check(!out_valid && byte_en == 0 && !mem_we && load_data == 0, "R8 idle after",
              {out_valid, mem_we, byte_en}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule